// File: doc/BRIEF.md
# Flag-Producing Shift Unit

This block shifts a 32-bit operand left logically, right logically or right arithmetically by a count from 0 to 63. Along with the shifted value it produces the condition flags an integer pipeline needs: the carry (the last bit shifted out), the extend flag, negative, zero and a cleared overflow. The carry and extend flags follow explicit rules for a zero count and for counts of 32 and above. The count is not masked to five bits.

The shift itself is a logarithmic network with one stage per count bit. It works on a double-width word, so the bit that falls off the end stays visible for the carry. Left shifts use the same right-shifting network by reversing the bits on the way in and on the way out. A parameter either registers the outputs, loading them only on cycles that present an operand, or passes them straight through. The previous carry and extend values are inputs, so a zero-count shift can return them unchanged.

Top module: `shf_flag_shifter`

## Requirements
- R1: With a count of zero the result equals the operand, C equals the carry input and X equals the extend input, whatever the operation.
- R2: Operation code 2'b00 is a logical left shift. For counts 1 to 31 the result is the operand shifted left with zeros filled in, and C is operand bit (32 - count).
- R3: For a logical left shift by exactly 32 the result is zero and C is operand bit 0. For counts 33 to 63 the result and C are both zero.
- R4: Operation code 2'b01 is a logical right shift. For counts 1 to 31 the result is the operand shifted right with zeros filled in, and C is operand bit (count - 1).
- R5: For a logical right shift by exactly 32 the result is zero and C is operand bit 31. For counts 33 to 63 the result and C are both zero.
- R6: Operation code 2'b10 is an arithmetic right shift. For counts 1 to 31 the vacated bits take operand bit 31 and C is operand bit (count - 1). For counts 32 to 63 every result bit and C equal operand bit 31.
- R7: For any non-zero count, X equals C.
- R8: N equals result bit 31, Z is 1 exactly when the result is zero, and V is always 0.
- R9: Operation code 2'b11 behaves exactly as a logical right shift.
- R10: With the output register enabled, the result and flags for an operand presented with in_valid high appear on the clock edge that samples it, and out_valid is high for that one cycle. While in_valid is low the outputs hold their last values.
- R11: While rst_n is low, out_valid is 0. After rst_n rises, out_valid stays 0 until an operand is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | 32 | Operand to shift |
| in_count | input | 6 | Shift count, 0 to 63 |
| in_op | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 right logical |
| in_carry | input | 1 | Previous carry flag, returned for a zero count |
| in_extend | input | 1 | Previous extend flag, returned for a zero count |
| out_valid | output | 1 | Result and flags valid |
| out_result | output | 32 | Shifted value |
| out_c | output | 1 | Carry flag |
| out_x | output | 1 | Extend flag |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag, always 0 |

## Verification
The boundary-count carry selection and the zero-flag generation can both be decided in the same cycle. A shift of exactly 32 empties the result and sets Z, while C must still take the last bit that crossed the boundary. Arithmetic shifts of a negative operand by large counts do the reverse: they fill the result with ones, so Z clears while C is 1. The bench drives every operation at counts 0, 1, 31, 32, 33 and 63 against operands chosen so that the bit picked for C differs from its neighbours. It then compares result, C, X, N, Z and V, each separately, against a model in the bench written directly from the count-range rules.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    SHF_LSL     = 2'b00,
    SHF_LSR     = 2'b01,
    SHF_ASR     = 2'b10,
    SHF_LSR_ALT = 2'b11
  } shf_op_e;

  typedef struct packed {
    logic c;
    logic x;
    logic n;
    logic z;
    logic v;
  } shf_flags_t;

endpackage

// File: rtl/shf_operand_prep.sv
module shf_operand_prep #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]   din,
  input  logic [1:0]          op,
  output logic [2*DATA_W-1:0] wide,
  output logic                fill
);
  import shf_pkg::*;

  logic [DATA_W-1:0] din_rev;
  logic              is_left;
  logic              is_arith;

  // Bit reversal lets a left shift reuse the right-shifting network.
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign din_rev[i] = din[DATA_W-1-i];
  end

  always_comb begin
    is_left  = (op == SHF_LSL);
    is_arith = (op == SHF_ASR);
    wide     = {(is_left ? din_rev : din), {DATA_W{1'b0}}};
    fill     = is_arith & din[DATA_W-1];
  end

endmodule

// File: rtl/shf_rshift_stages.sv
module shf_rshift_stages #(
  parameter int unsigned WIDE_W = 64,
  parameter int unsigned CNT_W  = 6
) (
  input  logic [WIDE_W-1:0] din,
  input  logic              fill,
  input  logic [CNT_W-1:0]  amt,
  output logic [WIDE_W-1:0] dout
);

  logic [WIDE_W-1:0] stage [CNT_W+1];

  assign stage[0] = din;

  // One stage per count bit; stage k moves the word by 2**k places.
  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int unsigned SH = 1 << k;
    assign stage[k+1] = amt[k] ? {{SH{fill}}, stage[k][WIDE_W-1:SH]} : stage[k];
  end

  assign dout = stage[CNT_W];

endmodule

// File: rtl/shf_flag_gen.sv
module shf_flag_gen #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0]   din,
  input  logic [2*DATA_W-1:0] shifted,
  input  logic [1:0]          op,
  input  logic                cnt_zero,
  input  logic                c_prev,
  input  logic                x_prev,
  output logic [DATA_W-1:0]   result,
  output shf_pkg::shf_flags_t flags
);
  import shf_pkg::*;

  logic [DATA_W-1:0] upper;
  logic [DATA_W-1:0] upper_rev;
  logic              out_bit;

  assign upper   = shifted[2*DATA_W-1:DATA_W];
  // The bit just below the kept half is the last one shifted out.
  assign out_bit = shifted[DATA_W-1];

  for (genvar i = 0; i < DATA_W; i++) begin : g_unrev
    assign upper_rev[i] = upper[DATA_W-1-i];
  end

  always_comb begin
    if (cnt_zero) begin
      result  = din;
      flags.c = c_prev;
      flags.x = x_prev;
    end else begin
      result  = (op == SHF_LSL) ? upper_rev : upper;
      flags.c = out_bit;
      flags.x = out_bit;
    end
    flags.n = result[DATA_W-1];
    flags.z = (result == '0);
    flags.v = 1'b0;
  end

endmodule

// File: rtl/shf_out_stage.sv
module shf_out_stage #(
  parameter int unsigned DATA_W  = 32,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   in_result,
  input  shf_pkg::shf_flags_t in_flags,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_result,
  output shf_pkg::shf_flags_t out_flags
);
  import shf_pkg::*;

  if (OUT_REG) begin : g_reg
    logic              valid_d, valid_q;
    logic              load_en;
    logic [DATA_W-1:0] result_d, result_q;
    shf_flags_t        flags_d, flags_q;

    always_comb begin
      load_en  = in_valid;
      valid_d  = in_valid;
      result_d = load_en ? in_result : result_q;
      flags_d  = load_en ? in_flags  : flags_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
      end else begin
        valid_q <= valid_d;
      end
    end

    always_ff @(posedge clk) begin
      if (load_en) begin
        result_q <= result_d;
        flags_q  <= flags_d;
      end
    end

    assign out_valid  = valid_q;
    assign out_result = result_q;
    assign out_flags  = flags_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign out_valid  = in_valid & rst_n;
    assign out_result = in_result;
    assign out_flags  = in_flags;
  end

endmodule

// File: rtl/shf_flag_shifter.sv
module shf_flag_shifter #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 6,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [1:0]        in_op,
  input  logic              in_carry,
  input  logic              in_extend,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_c,
  output logic              out_x,
  output logic              out_n,
  output logic              out_z,
  output logic              out_v
);
  import shf_pkg::*;

  localparam int unsigned WIDE_W = 2 * DATA_W;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [WIDE_W-1:0] prep_word;
  logic              prep_fill;
  logic [WIDE_W-1:0] shifted_word;
  logic              cnt_zero;
  logic [DATA_W-1:0] comb_result;
  shf_flags_t        comb_flags;
  shf_flags_t        reg_flags;

  // Reset asserts at once and is released on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  assign cnt_zero = (in_count == '0);

  shf_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .din  (in_data),
    .op   (in_op),
    .wide (prep_word),
    .fill (prep_fill)
  );

  shf_rshift_stages #(.WIDE_W(WIDE_W), .CNT_W(CNT_W)) u_shift (
    .din  (prep_word),
    .fill (prep_fill),
    .amt  (in_count),
    .dout (shifted_word)
  );

  shf_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .din      (in_data),
    .shifted  (shifted_word),
    .op       (in_op),
    .cnt_zero (cnt_zero),
    .c_prev   (in_carry),
    .x_prev   (in_extend),
    .result   (comb_result),
    .flags    (comb_flags)
  );

  shf_out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .in_valid   (in_valid),
    .in_result  (comb_result),
    .in_flags   (comb_flags),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_flags  (reg_flags)
  );

  assign out_c = reg_flags.c;
  assign out_x = reg_flags.x;
  assign out_n = reg_flags.n;
  assign out_z = reg_flags.z;
  assign out_v = reg_flags.v;

endmodule

// File: rtl/shf_flag_shifter_chk.sv
module shf_flag_shifter_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 6,
  parameter bit          OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic [CNT_W-1:0]  in_count,
  input logic [1:0]        in_op,
  input logic              in_carry,
  input logic              in_extend,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic              out_c,
  input logic              out_x,
  input logic              out_n,
  input logic              out_z,
  input logic              out_v
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) past_ok <= 1'b0;
    else             past_ok <= 1'b1;
  end

  if (OUT_REG) begin : g_chk
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
      past_ok |-> (out_valid == $past(in_valid)));

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (past_ok && !$past(in_valid)) |-> ($stable(out_result) && $stable(out_c) && $stable(out_x)));

    assert_zero_count_passthru_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (past_ok && $past(in_valid && (in_count == '0))) |->
        (out_result == $past(in_data) && out_c == $past(in_carry) && out_x == $past(in_extend)));

    assert_extend_tracks_carry_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (past_ok && $past(in_valid && (in_count != '0))) |-> (out_x == out_c));

    assert_left_overshift_clear_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (past_ok && $past(in_valid && in_op == 2'b00 && in_count > 6'd32)) |->
        (out_result == '0 && !out_c));

    assert_arith_overshift_sign_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (past_ok && $past(in_valid && in_op == 2'b10 && in_count >= 6'd32)) |->
        (out_result == {DATA_W{$past(in_data[DATA_W-1])}} && out_c == $past(in_data[DATA_W-1])));

    assert_flags_consistent_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
      out_valid |-> (out_n == out_result[DATA_W-1] && out_z == (out_result == '0) && !out_v));
  end

endmodule

bind shf_flag_shifter shf_flag_shifter_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .in_data    (in_data),
  .in_count   (in_count),
  .in_op      (in_op),
  .in_carry   (in_carry),
  .in_extend  (in_extend),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_c      (out_c),
  .out_x      (out_x),
  .out_n      (out_n),
  .out_z      (out_z),
  .out_v      (out_v)
);

// File: tb/tb_shf_flag_shifter.sv
`timescale 1ns/1ps
module tb_shf_flag_shifter;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic [5:0]  in_count;
  logic [1:0]  in_op;
  logic        in_carry;
  logic        in_extend;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_c, out_x, out_n, out_z, out_v;

  typedef struct packed {
    logic [31:0] r;
    logic        c;
    logic        x;
    logic [23:0] tag;
  } exp_t;

  exp_t        sb_q[$];
  exp_t        last_exp;
  logic        have_last;
  int          n_cmp;
  int          n_bad;
  int          cycles;
  logic        mon_en;

  shf_flag_shifter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_count(in_count), .in_op(in_op), .in_carry(in_carry), .in_extend(in_extend),
    .out_valid(out_valid), .out_result(out_result), .out_c(out_c), .out_x(out_x),
    .out_n(out_n), .out_z(out_z), .out_v(out_v)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Expected values written from the count-range rules.
  function automatic exp_t model(logic [31:0] d, int cnt, logic [1:0] op, logic ci, logic xi);
    exp_t e;
    e.r = '0; e.c = 1'b0; e.x = 1'b0;
    if (cnt == 0) begin
      e.r = d; e.c = ci; e.x = xi; e.tag = "R1";
    end else begin
      case (op)
        2'b00: begin
          e.tag = (cnt < 32) ? "R2" : "R3";
          if (cnt < 32)       begin e.r = d << cnt; e.c = d[32-cnt]; end
          else if (cnt == 32) begin e.r = '0; e.c = d[0]; end
          else                begin e.r = '0; e.c = 1'b0; end
        end
        2'b10: begin
          e.tag = "R6";
          if (cnt < 32) begin e.r = 32'($signed(d) >>> cnt); e.c = d[cnt-1]; end
          else          begin e.r = {32{d[31]}}; e.c = d[31]; end
        end
        default: begin
          e.tag = (op == 2'b11) ? "R9" : ((cnt < 32) ? "R4" : "R5");
          if (cnt < 32)       begin e.r = d >> cnt; e.c = d[cnt-1]; end
          else if (cnt == 32) begin e.r = '0; e.c = d[31]; end
          else                begin e.r = '0; e.c = 1'b0; end
        end
      endcase
      e.x = e.c;
    end
    return e;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(logic [31:0] d, int cnt, logic [1:0] op, logic ci, logic xi);
    @(negedge clk);
    in_valid  = 1'b1;
    in_data   = d;
    in_count  = 6'(cnt);
    in_op     = op;
    in_carry  = ci;
    in_extend = xi;
    sb_q.push_back(model(d, cnt, op, ci, xi));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 32'hDEAD_BEEF;
      in_count = 6'd5;
    end
  endtask

  // Monitor: pops the scoreboard when a result appears, else checks hold.
  always @(negedge clk) begin
    if (mon_en) begin
      if (out_valid) begin
        if (sb_q.size() == 0) begin
          chk("R10 unexpected out_valid", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk({string'(e.tag), " result"}, out_result, e.r);
          chk({string'(e.tag), " carry"}, {31'd0, out_c}, {31'd0, e.c});
          chk((e.tag == "R1") ? "R1 extend" : "R7 extend", {31'd0, out_x}, {31'd0, e.x});
          chk("R8 negative", {31'd0, out_n}, {31'd0, e.r[31]});
          chk("R8 zero", {31'd0, out_z}, {31'd0, (e.r == 32'd0)});
          chk("R8 overflow", {31'd0, out_v}, 32'd0);
          last_exp  = e;
          have_last = 1'b1;
        end
      end else if (have_last) begin
        chk("R10 hold result", out_result, last_exp.r);
        chk("R10 hold carry", {31'd0, out_c}, {31'd0, last_exp.c});
      end
    end
  end

  // Watchdog: a hung run counts as one failure and still reports.
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    int          cnts [8];
    n_cmp = 0; n_bad = 0; cycles = 0; mon_en = 1'b0; have_last = 1'b0;
    in_valid = 1'b0; in_data = '0; in_count = '0; in_op = '0; in_carry = 1'b0; in_extend = 1'b0;
    rst_n = 1'b0;
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'h0000_0000; pats[3] = 32'hA5C3_3C5A;
    cnts[0] = 0; cnts[1] = 1; cnts[2] = 31; cnts[3] = 32;
    cnts[4] = 33; cnts[5] = 63; cnts[6] = 16; cnts[7] = 2;

    repeat (3) @(negedge clk);
    chk("R11 valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 valid after release", {31'd0, out_valid}, 32'd0);
    mon_en = 1'b1;

    // Directed corners: every op, boundary counts, differing carry sources.
    for (int op = 0; op < 4; op++) begin
      for (int p = 0; p < 4; p++) begin
        for (int k = 0; k < 8; k++) begin
          send(pats[p], cnts[k], 2'(op), 1'(k[0]), 1'(~k[1]));
        end
      end
    end
    idle(3);

    // Negative operand with large arithmetic counts (R6) and zero count.
    send(32'hFFFF_FFFF, 40, 2'b10, 1'b0, 1'b0);
    send(32'h8000_0000, 0, 2'b00, 1'b1, 1'b0);
    send(32'h0000_0001, 32, 2'b00, 1'b0, 1'b1);
    idle(2);

    // Random traffic with gaps to exercise the hold rule.
    for (int i = 0; i < 600; i++) begin
      send($urandom, int'($urandom_range(0, 63)), 2'($urandom_range(0, 3)),
           1'($urandom), 1'($urandom));
      if ((i % 7) == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(3);

    // Reset in mid-run drives out_valid low at once (R11).
    send(32'h1234_5678, 4, 2'b01, 1'b0, 1'b0);
    idle(2);
    mon_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 valid on reset assert", {31'd0, out_valid}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 valid after second release", {31'd0, out_valid}, 32'd0);
    chk("R10 scoreboard drained", 32'(sb_q.size()), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule